// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of the finite field GF(2^12). The field is not built on a single degree-12 polynomial. It is a quadratic extension over GF(64). Each operand splits into an upper 6-bit half and a lower 6-bit half. Four GF(64) products are formed and folded together into the 12-bit result.

A second mode serves Reed-Solomon set-up code, which steps through generator roots. In this mode the block multiplies its first operand by the fixed constant 0xE01 and ignores the second operand. A zero input is mapped to one, so the root sequence can start from an empty state.

Each operation is accepted through a valid/ready handshake. The result is registered and presented with its own valid/ready pair, one result per accepted operation.

Top module: `gf12_tower_mul`

## Requirements
- R1: GF(64) products reduce by x^6+x+1. When a doubling carries out of bit 5, the value is XORed with 0x03. Example: operands 0x020 and 0x002 in multiply mode give 0x003.
- R2: In multiply mode, result bits 11:6 equal (ah^al)*(bh^bl) ^ al*bl in GF(64), where ah/al are bits 11:6 and 5:0 of op_a, and bh/bl are the same fields of op_b.
- R3: In multiply mode, result bits 5:0 equal (ah*bh)*0x21 ^ al*bl in GF(64).
- R4: In root mode (op_sel = 1), an op_a of 0 gives a result of 0x001.
- R5: In root mode, a nonzero op_a gives op_a multiplied by 0xE01 under the R2/R3 rules, and op_b has no effect on the result.
- R6: An operation is accepted on a rising edge where in_valid and in_ready are both 1. out_valid is 1 after that same edge and carries that operation's result.
- R7: In multiply mode, a zero operand gives 0. An op_b of 0x001 returns op_a unchanged.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0, and result and out_valid hold. Otherwise in_ready is 1.
- R9: While rst is high, out_valid goes to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op_sel | input | 1 | 0 = multiply op_a by op_b, 1 = root step on op_a |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand (multiply mode only) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| result | output | 12 | Product or root-step value |

## Verification
The hardest case to reach from the ports is an operation offered while the output is stalled: it must be refused, and the held result must stay intact. The stimulus holds out_ready low after an accepted operation and then offers a different operation with in_valid high for several cycles. It then checks that both the held result and the later result are correct. The reduction path is reached with directed operands whose halves carry out of bit 5. Random operands in both modes cover the tower combination.

// File: rtl/gf12_pkg.sv
package gf12_pkg;
    localparam int unsigned HALF_W = 6;
    localparam int unsigned FULL_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [FULL_W-1:0] elem_t;

    typedef struct packed {
        half_t hi;
        half_t lo;
    } split_t;

    typedef enum logic {
        OP_MUL  = 1'b0,
        OP_ROOT = 1'b1
    } op_e;

    // Low taps of x^6+x+1 applied when a doubling overflows bit 5
    localparam half_t RED_TAPS = 6'h03;
    // Twist constant folded into the low half of the extension product
    localparam half_t TWIST_K  = 6'h21;
    // Fixed multiplier for the root-generator step
    localparam elem_t ROOT_K   = 12'hE01;
endpackage

// File: rtl/gf_sub_mul.sv
module gf_sub_mul #(
    parameter int unsigned W = 6,
    parameter logic [W-1:0] TAPS = 6'h03
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    logic [W-1:0] acc [0:W];
    logic [W-1:0] sh  [0:W-1];

    assign acc[0] = '0;
    assign sh[0]  = b;

    for (genvar i = 0; i < W; i++) begin : g_step
        assign acc[i+1] = acc[i] ^ (a[i] ? sh[i] : '0);
        if (i < W - 1) begin : g_dbl
            // Shift up; a carry out of the top bit folds back through the taps
            assign sh[i+1] = {sh[i][W-2:0], 1'b0} ^ (sh[i][W-1] ? TAPS : '0);
        end
    end

    assign p = acc[W];
endmodule

// File: rtl/gf_tower_mul.sv
module gf_tower_mul
    import gf12_pkg::*;
#(
    parameter int unsigned HW = HALF_W,
    parameter logic [HW-1:0] TAPS = RED_TAPS,
    parameter logic [HW-1:0] TWIST = TWIST_K
) (
    input  logic [2*HW-1:0] x,
    input  logic [2*HW-1:0] y,
    output logic [2*HW-1:0] p
);
    logic [HW-1:0] xh, xl, yh, yl;
    logic [HW-1:0] p_sum, p_low, p_high, p_tw;

    assign xh = x[2*HW-1:HW];
    assign xl = x[HW-1:0];
    assign yh = y[2*HW-1:HW];
    assign yl = y[HW-1:0];

    gf_sub_mul #(.W(HW), .TAPS(TAPS)) u_sum  (.a(xh ^ xl), .b(yh ^ yl), .p(p_sum));
    gf_sub_mul #(.W(HW), .TAPS(TAPS)) u_low  (.a(xl),      .b(yl),      .p(p_low));
    gf_sub_mul #(.W(HW), .TAPS(TAPS)) u_high (.a(xh),      .b(yh),      .p(p_high));
    gf_sub_mul #(.W(HW), .TAPS(TAPS)) u_tw   (.a(p_high),  .b(TWIST),   .p(p_tw));

    assign p = {p_sum ^ p_low, p_tw ^ p_low};
endmodule

// File: rtl/gf_operand_sel.sv
module gf_operand_sel
    import gf12_pkg::*;
#(
    parameter int unsigned FW = FULL_W,
    parameter logic [FW-1:0] KROOT = ROOT_K
) (
    input  op_e           sel,
    input  logic [FW-1:0] a_in,
    input  logic [FW-1:0] b_in,
    output logic [FW-1:0] x,
    output logic [FW-1:0] y,
    output logic          force_one
);
    always_comb begin
        x         = a_in;
        y         = b_in;
        force_one = 1'b0;
        if (sel == OP_ROOT) begin
            y         = KROOT;
            force_one = (a_in == '0);
        end
    end
endmodule

// File: rtl/gf12_tower_mul.sv
module gf12_tower_mul
    import gf12_pkg::*;
#(
    parameter int unsigned HW = HALF_W,
    parameter logic [HW-1:0] TAPS = RED_TAPS,
    parameter logic [HW-1:0] TWIST = TWIST_K,
    parameter logic [2*HW-1:0] KROOT = ROOT_K
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            op_sel,
    input  logic [2*HW-1:0] op_a,
    input  logic [2*HW-1:0] op_b,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [2*HW-1:0] result
);
    localparam int unsigned FW = 2 * HW;
    localparam logic [FW-1:0] ONE = FW'(1);

    op_e           sel;
    logic [FW-1:0] x, y, prod;
    logic          force_one, accept;
    logic          vld_q;
    logic [FW-1:0] res_q;

    assign sel = op_e'(op_sel);

    gf_operand_sel #(.FW(FW), .KROOT(KROOT)) u_sel (
        .sel(sel), .a_in(op_a), .b_in(op_b),
        .x(x), .y(y), .force_one(force_one)
    );

    gf_tower_mul #(.HW(HW), .TAPS(TAPS), .TWIST(TWIST)) u_mul (
        .x(x), .y(y), .p(prod)
    );

    assign in_ready = !vld_q || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            if (accept) begin
                vld_q <= 1'b1;
                res_q <= force_one ? ONE : prod;
            end else if (out_ready) begin
                vld_q <= 1'b0;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q;

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(result)));
    a_r8_ready: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
    a_r4_root_zero: assert property (@(posedge clk) disable iff (rst)
        (accept && op_sel && op_a == '0) |=> (result == ONE));
    a_r7_zero: assert property (@(posedge clk) disable iff (rst)
        (accept && !op_sel && (op_a == '0 || op_b == '0)) |=> (result == '0));
    a_r7_one: assert property (@(posedge clk) disable iff (rst)
        (accept && !op_sel && op_b == ONE) |=> (result == $past(op_a)));
    a_r9_reset: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

// File: tb/sim_gf12_tower_mul.sv
module sim_gf12_tower_mul;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        op_sel = 1'b0;
    logic [11:0] op_a = '0;
    logic [11:0] op_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [11:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gf12_tower_mul u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .out_ready(out_ready), .result(result)
    );

    function automatic logic [5:0] m64(logic [5:0] a, logic [5:0] b);
        logic [5:0] c = '0;
        logic [6:0] t = {1'b0, b};
        for (int i = 0; i < 6; i++) begin
            if (a[i]) c ^= t[5:0];
            t = t << 1;
            if (t[6]) t ^= 7'h43;
        end
        return c;
    endfunction

    function automatic logic [11:0] m4096(logic [11:0] a, logic [11:0] b);
        logic [5:0] hi, lo;
        hi = m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ m64(a[5:0], b[5:0]);
        lo = m64(m64(a[11:6], b[11:6]), 6'h21) ^ m64(a[5:0], b[5:0]);
        return {hi, lo};
    endfunction

    function automatic logic [11:0] model(logic s, logic [11:0] a, logic [11:0] b);
        if (s) return (a == 12'h000) ? 12'h001 : m4096(a, 12'hE01);
        return m4096(a, b);
    endfunction

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(string req, logic s, logic [11:0] a, logic [11:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = s; op_a = a; op_b = b; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 12'(out_valid), 12'h001);
        check(req, result, model(s, a, b));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset out_valid", 12'(out_valid), 12'h000);
        check("R8 reset in_ready", 12'(in_ready), 12'h001);
        rst = 1'b0;

        // R1: carry out of bit 5 folds back through x+1
        run_op("R1", 1'b0, 12'h020, 12'h002);
        check("R1 known value", result, 12'h003);
        run_op("R1", 1'b0, 12'h03F, 12'h03F);
        run_op("R2 high half", 1'b0, 12'hFC0, 12'h040);
        run_op("R3 low half", 1'b0, 12'h040, 12'h040);
        run_op("R2", 1'b0, 12'hFFF, 12'hFFF);
        run_op("R7 zero", 1'b0, 12'h000, 12'hABC);
        check("R7 zero a", result, 12'h000);
        run_op("R7 zero", 1'b0, 12'h5A5, 12'h000);
        check("R7 zero b", result, 12'h000);
        run_op("R7 one", 1'b0, 12'h9C3, 12'h001);
        check("R7 one", result, 12'h9C3);
        run_op("R4 root zero", 1'b1, 12'h000, 12'h777);
        check("R4", result, 12'h001);
        run_op("R5 root one", 1'b1, 12'h001, 12'h123);
        check("R5", result, 12'hE01);
        run_op("R5 root", 1'b1, 12'h456, 12'h000);
        held = result;
        run_op("R5 b ignored", 1'b1, 12'h456, 12'hFFF);
        check("R5 b ignored", result, held);

        // R6: with no new offer, out_valid falls after one taken cycle
        @(negedge clk);
        check("R6 drop", 12'(out_valid), 12'h000);

        // R8: stall the output, then offer an operation that must be refused
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; op_sel = 1'b0; op_a = 12'h321; op_b = 12'h0F7;
        @(negedge clk);
        held = result;
        check("R6 stalled", result, model(1'b0, 12'h321, 12'h0F7));
        op_a = 12'hBEE; op_b = 12'h0AA;
        repeat (3) begin
            @(negedge clk);
            check("R8 ready low", 12'(in_ready), 12'h000);
            check("R8 valid hold", 12'(out_valid), 12'h001);
            check("R8 result hold", result, held);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 after release", result, model(1'b0, 12'hBEE, 12'h0AA));

        for (int k = 0; k < 400; k++) begin
            logic s;
            s = 1'($urandom() & 1);
            run_op(s ? "R5 random" : "R2 R3 random", s,
                   12'($urandom()), 12'($urandom()));
        end

        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R9 reset mid-run", 12'(out_valid), 12'h000);
        rst = 1'b0; in_valid = 1'b0;
        finish_run();
    end
endmodule